// File: doc/BRIEF.md
# Health-Test Alert Threshold Tracker

This block sits behind the statistical health tests of an entropy pipeline. Each time a test window finishes, it receives a strobe and one flag saying whether any test in that window failed. It keeps a saturating summary count of failing windows. When that count reaches a programmable threshold, it issues a single one-cycle recoverable alert request and latches an alert-active condition. While the alert is active, seed release is blocked and passing windows no longer reset the count. The alert episode is sticky: it ends only when the pipeline is disabled.

Before the tracker counts again, software must clear a latched alert status bit by writing one to it. The normal recovery order is: drop the pipeline enable, write one to the status bit, then raise the enable again. A second status bit records that a health test failed. Software clears it with its own write-one-to-clear strobe.

A small state machine controls the block. Its states are `ST_IDLE` (pipeline off or waiting for status clear), `ST_COUNT` (counting with no alert) and `ST_ALERT` (alert episode in progress). Its transitions are:
- `ST_IDLE`→`ST_COUNT`: on enable with the status bit clear.
- `ST_COUNT`→`ST_ALERT`: on the failing window that reaches the threshold.
- Any state→`ST_IDLE`: whenever the enable is low.

Top module: `health_alert_tracker`

## Requirements
- R1: After reset, the state is `ST_IDLE`. `fail_count`, `alert_active`, `alert_req`, `alert_sts`, `intr_ht_fail` and `seed_release` are all 0.
- R2: In `ST_COUNT` or `ST_ALERT` with `pipe_en` high, a `win_done` with `win_fail` high increments `fail_count` on the next clock. In `ST_IDLE`, windows are ignored.
- R3: `fail_count` saturates at its all-ones value instead of wrapping.
- R4: In `ST_COUNT`, a failing window whose incremented count is greater than or equal to a non-zero `thresh` has these effects on the next clock:
  - `alert_req` pulses for exactly one cycle.
  - `alert_active` goes to 1.
  - `alert_sts` sets.
- R5: While `alert_active` is 1, further failing windows raise no `alert_req`, even when the count meets the threshold again.
- R6: A passing window (`win_done` with `win_fail` low) clears `fail_count` in `ST_COUNT`. In `ST_ALERT` the count is left unchanged.
- R7: A `thresh` of 0 disables alerting: no `alert_req` is ever issued.
- R8: `pipe_en` low for one clock moves the block to `ST_IDLE` and clears `fail_count` and `alert_active`. `alert_sts` is kept.
- R9: `ST_IDLE` moves to `ST_COUNT` only when `pipe_en` is high and either `alert_sts` is 0 or `sts_w1c` is high in that same cycle.
- R10: `alert_sts` clears when `sts_w1c` is 1. A new alert in the same cycle takes priority and sets it.
- R11: `intr_ht_fail` sets on any failing window counted under R2, and clears on `intr_w1c`. A set in the same cycle wins over the clear.
- R12: `seed_release` equals `seed_avail` in `ST_COUNT` and is 0 otherwise. It is combinational, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| pipe_en | input | 1 | Pipeline enable; low is a disable event |
| win_done | input | 1 | Health-test window complete strobe |
| win_fail | input | 1 | Any test failed in the completed window |
| thresh | input | W | Alert threshold on the summary count; 0 disables |
| sts_w1c | input | 1 | Write-one-to-clear of the alert status bit |
| intr_w1c | input | 1 | Write-one-to-clear of the health-fail interrupt bit |
| seed_avail | input | 1 | A seed is ready to be released |
| fail_count | output | W | Summary failing-window count |
| alert_active | output | 1 | Alert episode in progress |
| alert_req | output | 1 | One-cycle recoverable alert request |
| alert_sts | output | 1 | Latched alert status bit |
| intr_ht_fail | output | 1 | Health-test-failed interrupt status |
| seed_release | output | 1 | Seed release permitted and requested |

## Verification
The bench targets the following corner cases:
- **Threshold reached inside an episode.** A design that re-armed the alert would pulse `alert_req` a second time.
- **Passing windows during an alert.** A design without the sticky rule would zero the count.
- **Enable raised without clearing the status bit.** A lenient design would resume counting and release seeds.
- **Long failure runs at threshold 0.** These expose a wrapping counter, and also any alert raised because 0 compared as met.

It also drives same-cycle set and clear of both status bits, and threshold changes on a count that already exceeds the new value.

// File: rtl/hta_pkg.sv
package hta_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ALERT = 2'd2
    } hta_state_e;
endpackage

// File: rtl/hta_sat_counter.sv
module hta_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_plus
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // next value if incremented, held at the ceiling
    always_comb begin
        if (cnt == CNT_MAX) cnt_plus = CNT_MAX;
        else                cnt_plus = cnt + {{(W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt_plus;
    end
endmodule

// File: rtl/hta_ctrl_fsm.sv
module hta_ctrl_fsm
    import hta_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pipe_en,
    input  logic         win_done,
    input  logic         win_fail,
    input  logic [W-1:0] thresh,
    input  logic [W-1:0] cnt_plus,
    input  logic         sts_now,
    input  logic         sts_w1c,
    output logic         cnt_clr,
    output logic         cnt_inc,
    output logic         fire,
    output logic         fail_seen,
    output logic         in_alert,
    output logic         in_count,
    output logic         alert_req
);
    hta_state_e state, state_nxt;
    logic       thresh_on;

    assign thresh_on = (thresh != '0);

    // transition and decode
    always_comb begin
        state_nxt = state;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        fire      = 1'b0;
        fail_seen = 1'b0;
        if (!pipe_en) begin
            state_nxt = ST_IDLE;
            cnt_clr   = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!sts_now || sts_w1c) state_nxt = ST_COUNT;
                end
                ST_COUNT: begin
                    if (win_done) begin
                        if (win_fail) begin
                            cnt_inc   = 1'b1;
                            fail_seen = 1'b1;
                            if (thresh_on && (cnt_plus >= thresh)) begin
                                fire      = 1'b1;
                                state_nxt = ST_ALERT;
                            end
                        end else begin
                            cnt_clr = 1'b1;
                        end
                    end
                end
                ST_ALERT: begin
                    if (win_done && win_fail) begin
                        cnt_inc   = 1'b1;
                        fail_seen = 1'b1;
                    end
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alert_req <= 1'b0;
        else        alert_req <= fire;
    end

    assign in_alert = (state == ST_ALERT);
    assign in_count = (state == ST_COUNT);
endmodule

// File: rtl/hta_status_bits.sv
module hta_status_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic sts_w1c,
    input  logic fail_seen,
    input  logic intr_w1c,
    output logic alert_sts,
    output logic intr_ht_fail
);
    // set wins over a same-cycle clear for both bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alert_sts    <= 1'b0;
            intr_ht_fail <= 1'b0;
        end else begin
            alert_sts    <= fire      | (alert_sts    & ~sts_w1c);
            intr_ht_fail <= fail_seen | (intr_ht_fail & ~intr_w1c);
        end
    end
endmodule

// File: rtl/health_alert_tracker.sv
module health_alert_tracker #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pipe_en,
    input  logic         win_done,
    input  logic         win_fail,
    input  logic [W-1:0] thresh,
    input  logic         sts_w1c,
    input  logic         intr_w1c,
    input  logic         seed_avail,
    output logic [W-1:0] fail_count,
    output logic         alert_active,
    output logic         alert_req,
    output logic         alert_sts,
    output logic         intr_ht_fail,
    output logic         seed_release
);
    logic [W-1:0] cnt_plus;
    logic         cnt_clr, cnt_inc, fire, fail_seen, in_count;

    hta_sat_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .cnt      (fail_count),
        .cnt_plus (cnt_plus)
    );

    hta_ctrl_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_en   (pipe_en),
        .win_done  (win_done),
        .win_fail  (win_fail),
        .thresh    (thresh),
        .cnt_plus  (cnt_plus),
        .sts_now   (alert_sts),
        .sts_w1c   (sts_w1c),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .fire      (fire),
        .fail_seen (fail_seen),
        .in_alert  (alert_active),
        .in_count  (in_count),
        .alert_req (alert_req)
    );

    hta_status_bits u_sts (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (fire),
        .sts_w1c      (sts_w1c),
        .fail_seen    (fail_seen),
        .intr_w1c     (intr_w1c),
        .alert_sts    (alert_sts),
        .intr_ht_fail (intr_ht_fail)
    );

    assign seed_release = seed_avail & in_count;
endmodule

// File: rtl/hta_checker.sv
module hta_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pipe_en,
    input logic         win_done,
    input logic         win_fail,
    input logic [W-1:0] thresh,
    input logic         sts_w1c,
    input logic         seed_avail,
    input logic [W-1:0] fail_count,
    input logic         alert_active,
    input logic         alert_req,
    input logic         alert_sts,
    input logic         seed_release
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alert_req |=> !alert_req);

    assert_req_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alert_req |-> alert_active && alert_sts);

    assert_no_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_active && pipe_en) |=> !alert_req && alert_active);

    assert_sticky_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_active && pipe_en && !(win_done && win_fail)) |=> $stable(fail_count));

    assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_count == CNT_MAX && pipe_en && win_done && win_fail) |=> fail_count == CNT_MAX);

    assert_thresh_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh == '0) |=> !alert_req);

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_en |=> !alert_active && fail_count == '0);

    assert_wait_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_en && alert_sts && !sts_w1c) |=> !seed_release || !seed_avail);

    assert_seed_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        seed_release |-> seed_avail && !alert_active);
endmodule

bind health_alert_tracker hta_checker #(.W(W)) u_hta_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pipe_en      (pipe_en),
    .win_done     (win_done),
    .win_fail     (win_fail),
    .thresh       (thresh),
    .sts_w1c      (sts_w1c),
    .seed_avail   (seed_avail),
    .fail_count   (fail_count),
    .alert_active (alert_active),
    .alert_req    (alert_req),
    .alert_sts    (alert_sts),
    .seed_release (seed_release)
);

// File: tb/test_health_alert_tracker.sv
module test_health_alert_tracker;
    localparam int W    = 8;
    localparam int CMAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pipe_en = 1'b0, win_done = 1'b0, win_fail = 1'b0;
    logic [W-1:0] thresh = '0;
    logic         sts_w1c = 1'b0, intr_w1c = 1'b0, seed_avail = 1'b0;
    logic [W-1:0] fail_count;
    logic         alert_active, alert_req, alert_sts, intr_ht_fail, seed_release;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state: 0 idle, 1 counting, 2 alerted
    int m_state = 0, m_cnt = 0;
    bit m_req = 0, m_sts = 0, m_intr = 0;

    always #2.5 clk = ~clk;

    health_alert_tracker #(.W(W)) i_health_alert_tracker (
        .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .win_done(win_done),
        .win_fail(win_fail), .thresh(thresh), .sts_w1c(sts_w1c),
        .intr_w1c(intr_w1c), .seed_avail(seed_avail), .fail_count(fail_count),
        .alert_active(alert_active), .alert_req(alert_req), .alert_sts(alert_sts),
        .intr_ht_fail(intr_ht_fail), .seed_release(seed_release)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check_eq("R2 fail_count",   int'(fail_count),  m_cnt);
        check_eq("R5 alert_active", int'(alert_active), int'(m_state == 2));
        check_eq("R4 alert_req",    int'(alert_req),    int'(m_req));
        check_eq("R10 alert_sts",   int'(alert_sts),    int'(m_sts));
        check_eq("R11 intr_ht_fail", int'(intr_ht_fail), int'(m_intr));
    endtask

    // one clock: drive after a falling edge, model at the rising edge
    task automatic step(input bit en, input bit wd, input bit wf, input int th,
                        input bit sw, input bit iw, input bit sa);
        int  ns, nc;
        bit  fire, seen;
        pipe_en = en; win_done = wd; win_fail = wf; thresh = th[W-1:0];
        sts_w1c = sw; intr_w1c = iw; seed_avail = sa;
        #1;
        check_eq("R12 seed_release", int'(seed_release), int'(sa && m_state == 1));
        @(posedge clk);
        ns = m_state; nc = m_cnt; fire = 0;
        seen = en && m_state != 0 && wd && wf;
        if (!en) begin
            ns = 0; nc = 0;
        end else if (m_state == 0) begin
            if (!m_sts || sw) ns = 1;
        end else if (m_state == 1) begin
            if (wd && wf) begin
                nc = (m_cnt < CMAX) ? m_cnt + 1 : CMAX;
                if (th != 0 && nc >= th) begin fire = 1; ns = 2; end
            end else if (wd) begin
                nc = 0;
            end
        end else begin
            if (wd && wf) nc = (m_cnt < CMAX) ? m_cnt + 1 : CMAX;
        end
        m_state = ns; m_cnt = nc; m_req = fire;
        m_sts  = fire || (m_sts && !sw);
        m_intr = seen || (m_intr && !iw);
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset values
        check_eq("R1 fail_count", int'(fail_count), 0);
        check_eq("R1 alert_active", int'(alert_active), 0);
        check_eq("R1 alert_req", int'(alert_req), 0);
        check_eq("R1 alert_sts", int'(alert_sts), 0);
        check_eq("R1 intr_ht_fail", int'(intr_ht_fail), 0);
        check_eq("R1 seed_release", int'(seed_release), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: idle ignores windows, then counting begins
        step(0, 1, 1, 3, 0, 0, 1);
        check_eq("R2 idle ignores", int'(fail_count), 0);
        step(1, 0, 0, 3, 0, 0, 1);
        step(1, 1, 1, 3, 0, 0, 1);
        step(1, 1, 1, 3, 0, 0, 1);
        check_eq("R2 two fails", int'(fail_count), 2);
        // R6: passing window clears while counting
        step(1, 1, 0, 3, 0, 1, 1);
        check_eq("R6 pass clears", int'(fail_count), 0);
        // R4: reach threshold 3
        repeat (3) step(1, 1, 1, 3, 0, 0, 1);
        check_eq("R4 req pulse", int'(alert_req), 1);
        check_eq("R4 active", int'(alert_active), 1);
        step(1, 0, 0, 3, 0, 0, 1);
        check_eq("R4 single pulse", int'(alert_req), 0);
        // R5 / R6: more fails, passes hold the count
        repeat (4) step(1, 1, 1, 3, 0, 0, 1);
        check_eq("R5 no rearm", int'(alert_req), 0);
        step(1, 1, 0, 3, 0, 0, 1);
        check_eq("R6 sticky count", int'(fail_count), 7);
        // R8: disable clears episode, status kept
        step(0, 0, 0, 3, 0, 0, 1);
        check_eq("R8 active cleared", int'(alert_active), 0);
        check_eq("R8 count cleared", int'(fail_count), 0);
        check_eq("R8 status kept", int'(alert_sts), 1);
        // R9: enable without status clear stays idle
        step(1, 1, 1, 3, 0, 0, 1);
        step(1, 0, 0, 3, 0, 0, 1);
        check_eq("R9 held idle", int'(seed_release), 0);
        check_eq("R9 no count", int'(fail_count), 0);
        step(1, 0, 0, 3, 1, 0, 1);
        check_eq("R9 status cleared", int'(alert_sts), 0);
        step(1, 0, 0, 3, 0, 0, 1);
        check_eq("R9 resumed", int'(seed_release), 1);
        // R10: alert and clear in the same cycle -> set wins
        step(1, 1, 1, 1, 1, 1, 0);
        check_eq("R10 set wins", int'(alert_sts), 1);
        check_eq("R11 set wins", int'(intr_ht_fail), 1);
        step(0, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 1, 1, 1, 0);
        check_eq("R11 cleared", int'(intr_ht_fail), 0);
        // R3 / R7: threshold 0 with a long failure run
        repeat (CMAX + 6) step(1, 1, 1, 0, 0, 0, 1);
        check_eq("R3 saturated", int'(fail_count), CMAX);
        check_eq("R7 no alert", int'(alert_active), 0);
        // lower threshold below a count already above it
        step(1, 1, 1, 5, 0, 0, 1);
        check_eq("R4 late threshold", int'(alert_req), 1);
        step(0, 0, 0, 5, 1, 0, 0);
        step(1, 0, 0, 5, 0, 0, 0);

        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r > 2, $urandom_range(0, 2) != 0, $urandom_range(0, 2) == 0,
                 $urandom_range(0, 6), $urandom_range(0, 15) == 0,
                 $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule